// File: doc/BRIEF.md
# Wide-Vector Power License Controller

This per-core controller sits between the issue logic of an execution core and the central power controller. It watches every issued operation. The first heavy vector operation it sees raises a voltage request. While that request waits for its grant, heavy vector issue is slowed to a configurable pace instead of stopping outright. The grant restores full throughput. From that point the core keeps its elevated mode until heavy activity has been absent for a long, parameterised quiet interval. A frequency-cap select tells the clocking logic to use the wide-vector limit for as long as the mode is held.

The controller is a four-state machine. IDLE is the normal mode. REQUESTING means the request is pending and throttling is active. LICENSED means the grant has arrived and heavy operations are still present. HOLDOFF means the grant is held while the quiet timer runs. Transitions:

- *enter*: IDLE to REQUESTING on a heavy operation.
- *grant*: REQUESTING to LICENSED on the acknowledge.
- *quiet*: LICENSED to HOLDOFF on a cycle with no heavy operation.
- *resume*: HOLDOFF to LICENSED on a heavy operation.
- *expire*: LICENSED or HOLDOFF to IDLE when the quiet timer completes.

Top module: `vlic_ctrl`

## Requirements
- R1: After reset the mode is IDLE (code 0), `volt_req`, `vec_throttle` and `freq_cap_sel` are 0, and `heavy_issue_ok` is 1.
- R2: An operation is heavy only when `op_valid`, `op_vec` and a width code of at least 1 are all present. Width codes: 0 = scalar or at most 64 bits, 1 = 128, 2 = 256, 3 = 512 bits. Scalar-width vector operations and non-vector operations never leave IDLE.
- R3: A heavy operation in IDLE moves the block to REQUESTING on the next cycle, with `volt_req`, `vec_throttle` and `freq_cap_sel` all at 1.
- R4: `volt_req` stays high without a break until `pc_ack` is seen. Heavy operations arriving while it is pending never re-issue it, and it rises only out of IDLE.
- R5: In REQUESTING, `heavy_issue_ok` allows at most one heavy operation every max(`pace_cfg`,1) cycles. After an accepted heavy operation it is low for `pace_cfg`-1 cycles.
- R6: `pc_ack` in REQUESTING moves the block to LICENSED on the next cycle. `volt_req` and `vec_throttle` drop to 0 and `heavy_issue_ok` returns to 1.
- R7: `pc_ack` in any state other than REQUESTING has no effect on the mode or on `volt_req`.
- R8: After the last heavy operation, HOLD_CYC consecutive quiet cycles return the block to IDLE, and `freq_cap_sel` returns to 0. Until then the mode is LICENSED or HOLDOFF.
- R9: A heavy operation in HOLDOFF returns the block to LICENSED and restarts the full quiet interval, without a new voltage request.
- R10: A heavy operation in the cycle in which the quiet interval would complete keeps the mode; the block goes to LICENSED, not IDLE.
- R11: `lic_mode` reports 0 = IDLE, 1 = REQUESTING, 2 = LICENSED, 3 = HOLDOFF. `freq_cap_sel` is 1 in every state except IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented for issue this cycle |
| op_vec | input | 1 | The operation uses the wide-vector encoding |
| op_wcode | input | 2 | Operand width code (0 scalar, 1 128-bit, 2 256-bit, 3 512-bit) |
| pace_cfg | input | PACE_W | Throttle spacing in cycles between heavy operations |
| pc_ack | input | 1 | Power controller reports that the voltage has been raised |
| volt_req | output | 1 | Voltage request to the power controller |
| vec_throttle | output | 1 | Heavy vector issue is being paced |
| heavy_issue_ok | output | 1 | A heavy operation may issue this cycle |
| freq_cap_sel | output | 1 | Select the wide-vector frequency limit |
| lic_mode | output | 2 | Current mode code |

## Verification
Two events can land in the same cycle. The first is the quiet timer completing while a fresh heavy operation arrives. The bench provokes it by counting exactly HOLD_CYC-1 quiet cycles after a heavy operation and then presenting another one. It judges the result by requiring LICENSED rather than IDLE, followed by a full new quiet interval. The second is an acknowledge arriving in the same cycle as a paced heavy operation during REQUESTING. That case must still yield the grant on the following cycle, with throttling removed.

// File: rtl/vlic_pkg.sv
package vlic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_LIC  = 2'd2,
        ST_HOLD = 2'd3
    } lic_state_e;

    localparam int WCODE_W = 2;
    localparam logic [WCODE_W-1:0] WCODE_MIN_HEAVY = 2'd1;

endpackage

// File: rtl/vlic_heavy_detect.sv
module vlic_heavy_detect
    import vlic_pkg::*;
(
    input  logic               op_valid,
    input  logic               op_vec,
    input  logic [WCODE_W-1:0] op_wcode,
    output logic               heavy
);
    // Scalar-width operations in vector encoding are excluded by the width floor.
    always_comb begin
        heavy = op_valid && op_vec && (op_wcode >= WCODE_MIN_HEAVY);
    end
endmodule

// File: rtl/vlic_pacer.sv
module vlic_pacer #(
    parameter int PACE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PACE_W-1:0] pace_cfg,
    input  logic              accept,
    output logic              ready
);
    logic [PACE_W-1:0] gap_q;
    logic [PACE_W-1:0] reload;

    always_comb begin
        reload = (pace_cfg == '0) ? '0 : pace_cfg - 1'b1;
        ready  = (gap_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (accept) begin
            gap_q <= reload;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end
endmodule

// File: rtl/vlic_quiet_timer.sv
module vlic_quiet_timer #(
    parameter int HOLD_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        expire = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vlic_ctrl.sv
module vlic_ctrl
    import vlic_pkg::*;
#(
    parameter int PACE_W   = 4,
    parameter int HOLD_CYC = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_vec,
    input  logic [1:0]        op_wcode,
    input  logic [PACE_W-1:0] pace_cfg,
    input  logic              pc_ack,
    output logic              volt_req,
    output logic              vec_throttle,
    output logic              heavy_issue_ok,
    output logic              freq_cap_sel,
    output logic [1:0]        lic_mode
);
    lic_state_e state_q, state_d;
    logic heavy, accept, pace_ready, quiet_run, quiet_done;

    vlic_heavy_detect u_detect (
        .op_valid (op_valid),
        .op_vec   (op_vec),
        .op_wcode (op_wcode),
        .heavy    (heavy)
    );

    vlic_pacer #(.PACE_W(PACE_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pace_cfg (pace_cfg),
        .accept   (accept),
        .ready    (pace_ready)
    );

    vlic_quiet_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (quiet_run),
        .expire (quiet_done)
    );

    always_comb begin
        accept    = heavy && heavy_issue_ok;
        quiet_run = ((state_q == ST_LIC) || (state_q == ST_HOLD)) && !heavy;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: enter, grant, quiet, resume, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (heavy)      state_d = ST_REQ;
            ST_REQ:  if (pc_ack)     state_d = ST_LIC;
            ST_LIC: begin
                if (heavy)           state_d = ST_LIC;
                else if (quiet_done) state_d = ST_IDLE;
                else                 state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (heavy)           state_d = ST_LIC;
                else if (quiet_done) state_d = ST_IDLE;
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        volt_req       = 1'b0;
        vec_throttle   = 1'b0;
        heavy_issue_ok = 1'b1;
        freq_cap_sel   = 1'b1;
        unique case (state_q)
            ST_IDLE: freq_cap_sel = 1'b0;
            ST_REQ: begin
                volt_req       = 1'b1;
                vec_throttle   = 1'b1;
                heavy_issue_ok = pace_ready;
            end
            ST_LIC, ST_HOLD: ;
            default: freq_cap_sel = 1'b0;
        endcase
        lic_mode = state_q;
    end
endmodule

// File: rtl/vlic_checks.sv
module vlic_checks #(
    parameter int PACE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_vec,
    input logic [1:0]        op_wcode,
    input logic [PACE_W-1:0] pace_cfg,
    input logic              pc_ack,
    input logic              volt_req,
    input logic              vec_throttle,
    input logic              heavy_issue_ok,
    input logic              freq_cap_sel,
    input logic [1:0]        lic_mode
);
    logic hv;
    always_comb hv = op_valid && op_vec && (op_wcode != 2'd0);

    p_light_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lic_mode == 2'd0 && !hv) |=> (lic_mode == 2'd0));

    p_enter_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lic_mode == 2'd0 && hv) |=> (volt_req && vec_throttle && freq_cap_sel));

    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_req && !pc_ack) |=> volt_req);

    p_req_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(volt_req) |-> ($past(lic_mode) == 2'd0));

    p_pace_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_throttle && !pc_ack && hv && heavy_issue_ok && pace_cfg >= 2 && $stable(pace_cfg))
        |=> !heavy_issue_ok);

    p_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_req && pc_ack) |=> (!volt_req && !vec_throttle && heavy_issue_ok && lic_mode == 2'd2));

    p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lic_mode == 2'd3 && hv) |=> (lic_mode == 2'd2 && !volt_req));

    p_cap_in_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lic_mode != 2'd0) |-> freq_cap_sel);
endmodule

bind vlic_ctrl vlic_checks #(.PACE_W(PACE_W)) u_vlic_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_vec         (op_vec),
    .op_wcode       (op_wcode),
    .pace_cfg       (pace_cfg),
    .pc_ack         (pc_ack),
    .volt_req       (volt_req),
    .vec_throttle   (vec_throttle),
    .heavy_issue_ok (heavy_issue_ok),
    .freq_cap_sel   (freq_cap_sel),
    .lic_mode       (lic_mode)
);

// File: tb/test_vlic_ctrl.sv
module test_vlic_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic op_valid, op_vec, pc_ack;
    logic [1:0] op_wcode;
    logic [PW-1:0] pace_cfg;
    logic volt_req, vec_throttle, heavy_issue_ok, freq_cap_sel;
    logic [1:0] lic_mode;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlic_ctrl #(.PACE_W(PW), .HOLD_CYC(HOLD)) i_vlic_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_vec(op_vec),
        .op_wcode(op_wcode), .pace_cfg(pace_cfg), .pc_ack(pc_ack),
        .volt_req(volt_req), .vec_throttle(vec_throttle),
        .heavy_issue_ok(heavy_issue_ok), .freq_cap_sel(freq_cap_sel),
        .lic_mode(lic_mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, sample just after the rising edge.
    task automatic cyc(input logic v, input logic vec, input logic [1:0] w, input logic ack);
        @(negedge clk);
        op_valid = v; op_vec = vec; op_wcode = w; pc_ack = ack;
        @(posedge clk);
        #1;
    endtask

    task automatic heavy_op();  cyc(1, 1, 2'd2, 0); endtask
    task automatic quiet();     cyc(0, 0, 2'd0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; op_valid = 0; op_vec = 0; op_wcode = 0; pc_ack = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode", lic_mode, 0);
        chk("R1 req", volt_req, 0);
        chk("R1 throttle", vec_throttle, 0);
        chk("R1 cap", freq_cap_sel, 0);
        chk("R1 issue_ok", heavy_issue_ok, 1);
    endtask

    task automatic t_light_ops();
        cyc(1, 1, 2'd0, 0); chk("R2 scalar vec op mode", lic_mode, 0);
        cyc(1, 0, 2'd3, 0); chk("R2 non-vec op mode", lic_mode, 0);
        cyc(0, 1, 2'd3, 0); chk("R2 invalid op mode", lic_mode, 0);
        cyc(0, 0, 2'd0, 1); chk("R7 ack in idle mode", lic_mode, 0);
        chk("R7 ack in idle req", volt_req, 0);
    endtask

    task automatic t_throttle();
        pace_cfg = 4'd3;
        cyc(1, 1, 2'd1, 0);
        chk("R3 mode", lic_mode, 1);
        chk("R3 req", volt_req, 1);
        chk("R3 throttle", vec_throttle, 1);
        chk("R11 cap", freq_cap_sel, 1);
        chk("R5 ok after first", heavy_issue_ok, 0);
        heavy_op(); chk("R5 ok gap 2", heavy_issue_ok, 0);
        chk("R4 req held", volt_req, 1);
        heavy_op(); chk("R5 ok open", heavy_issue_ok, 1);
        heavy_op(); chk("R5 ok after paced op", heavy_issue_ok, 0);
        chk("R4 req still held", volt_req, 1);
        chk("R11 mode code req", lic_mode, 1);
        cyc(1, 1, 2'd3, 1);
        chk("R6 mode", lic_mode, 2);
        chk("R6 req", volt_req, 0);
        chk("R6 throttle", vec_throttle, 0);
        chk("R6 ok", heavy_issue_ok, 1);
    endtask

    task automatic t_ack_ignored();
        cyc(1, 1, 2'd2, 1);
        chk("R7 ack licensed mode", lic_mode, 2);
        chk("R7 ack licensed req", volt_req, 0);
    endtask

    task automatic t_holdoff();
        heavy_op();
        quiet(); chk("R11 mode code hold", lic_mode, 3);
        for (int k = 2; k < HOLD; k++) quiet();
        chk("R8 before expiry mode", lic_mode, 3);
        cyc(0, 0, 2'd0, 1);
        chk("R8 expired mode", lic_mode, 0);
        chk("R8 cap released", freq_cap_sel, 0);
    endtask

    task automatic t_resume();
        pace_cfg = 4'd1;
        heavy_op();
        chk("R5 pace1 ok", heavy_issue_ok, 1);
        heavy_op();
        chk("R5 pace1 ok again", heavy_issue_ok, 1);
        cyc(0, 0, 2'd0, 1);
        chk("R6 grant pace1", lic_mode, 2);
        heavy_op();
        for (int k = 0; k < 5; k++) quiet();
        chk("R9 in hold", lic_mode, 3);
        heavy_op();
        chk("R9 resume mode", lic_mode, 2);
        chk("R9 no new req", volt_req, 0);
        for (int k = 1; k < HOLD; k++) quiet();
        chk("R9 full interval mode", lic_mode, 3);
        quiet();
        chk("R9 expiry after restart", lic_mode, 0);
    endtask

    task automatic t_tie();
        pace_cfg = 4'd2;
        heavy_op();
        cyc(1, 1, 2'd1, 1);
        chk("R6 grant with paced op", lic_mode, 2);
        heavy_op();
        for (int k = 1; k < HOLD; k++) quiet();
        chk("R10 at edge mode", lic_mode, 3);
        heavy_op();
        chk("R10 heavy wins", lic_mode, 2);
        for (int k = 0; k < HOLD; k++) quiet();
        chk("R10 drained", lic_mode, 0);
    endtask

    initial begin
        pace_cfg = 4'd3;
        t_reset();
        t_light_ops();
        t_throttle();
        t_ack_ignored();
        t_holdoff();
        t_resume();
        t_tie();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule